// File: doc/BRIEF.md
# Bypassable Halfband Decimation Chain

This block sits on the receive side between a converter-rate complex sample stream and a lower-rate baseband output. Signed I/Q samples arrive with a valid strobe and pass through three halfband stages in a row: an entry stage at the full input rate, a middle stage, and an exit stage. Each stage either decimates by two or passes samples straight through at its input rate. With all three active, a 480 MS/s input leaves the block at 60 MS/s.

A 7-bit control word enables the channel and picks which stages decimate. The block also reports, as a count of input-rate samples, the total group delay that the chosen stages add. Each stage keeps its own delay line, uses symmetric halfband coefficients in which only the centre tap and the odd-offset taps are non-zero, and rounds and saturates its result back to the sample width. A change to the control word flushes every stage, so no stage ever mixes data taken at two different rates.

Top module: `rx_hb_decim_chain`

## Requirements
- R1: Control word decode: bit 6 enables the channel. Bits 5:4 equal to 01 make the entry stage decimate, and any other value bypasses it. Bit 3 turns on the middle stage and bit 2 turns on the exit stage. Bits 1:0 have no effect on the data path or on the reported delay, and changing only those bits causes no flush.
- R2: An active stage emits one output for every second sample it accepts. The first output after a flush uses the first two accepted samples. The output count from N accepted inputs (N divisible by 2^k) is N/2^k, where k is the number of active stages.
- R3: Each stage has unity DC gain. A constant input x gives a settled output of exactly x on both lanes in every configuration.
- R4: The stages have orders 4 (entry), 6 (middle) and 14 (exit), with Q15 coefficients. The centre tap is 16384 and the off-centre pairs are 8192 (order 4); 9216 and -1024 (order 6); 9984, -2432, 896 and -256 (order 14). With only the entry stage active after a flush, the input 0, 1024, 0, 0, 0, 0 gives outputs 0, 512, 0.
- R5: Each stage output is the Q15 sum rounded to nearest with ties toward positive infinity. With only the entry stage active after a flush, the I input 2, 0 gives 1, and the Q input -2, 0 gives 0.
- R6: A stage result above 2047 becomes 2047, and one below -2048 becomes -2048. The result never wraps.
- R7: `latency` equals the sum over active stages of order/2, scaled by 2 for each active stage ahead of it. All three active gives 36, and a disabled channel gives 0. It takes the new value one clock after the control word changes.
- R8: While bit 6 is clear, `out_valid` is low from the next clock on and inputs are dropped. On re-enable every delay line starts from zero, so the entry stage alone fed 1000, 1000 first outputs 250.
- R9: A change of the decoded control word flushes all stages, even while samples are streaming. The sample presented in the flush cycle is dropped, and later samples see empty history.
- R10: A bypassed stage forwards every accepted sample unchanged with one clock of delay. With all stages bypassed, an input shows at the output three clocks later.
- R11: During reset `out_valid` and `latency` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the converter sample rate |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 7 | Channel enable and stage selection |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 12 | Input in-phase sample, two's complement |
| in_q | input | 12 | Input quadrature sample, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 12 | Output in-phase sample |
| out_q | output | 12 | Output quadrature sample |
| latency | output | 6 | Group delay of the requested configuration, in input samples |

## Verification
The assertions check the following on every cycle: the output stays silent after the channel is switched off, decimating stages never emit on two clocks in a row, bypassed stages forward each sample one clock later, results that run past the range are clipped, and the reported delay holds steady while the control word does. Only the bench scenarios can show the filter arithmetic itself. That covers exact DC gain, the impulse shape and the rounding of ties. The bench also checks the output counts per configuration, and that flushes on disable and on a reconfiguration while streaming clear the history.

// File: rtl/hbdec_pkg.sv
package hbdec_pkg;

  // Coefficient scaling: unity gain equals 1 << HB_FRAC
  localparam int HB_FRAC = 15;

  typedef struct packed {
    logic en;   // channel on
    logic s1;   // entry stage decimates
    logic s2;   // middle stage decimates
    logic s3;   // exit stage decimates
  } chain_cfg_t;

  // Bits 1:0 are deliberately not part of the decoded configuration.
  function automatic chain_cfg_t decode_ctrl(input logic [6:0] w);
    chain_cfg_t c;
    c.en = w[6];
    c.s1 = (w[5:4] == 2'b01);
    c.s2 = w[3];
    c.s3 = w[2];
    return c;
  endfunction

  // Off-centre coefficient for offset 2k+1, given the number of non-zero pairs.
  // Every set sums to 8192 per side, so both sides plus the 16384 centre give unity.
  function automatic int hb_coef(input int pairs, input int k);
    int c;
    c = 0;
    if (pairs == 1) c = 8192;
    else if (pairs == 2) c = (k == 0) ? 9216 : -1024;
    else if (pairs == 3) c = (k == 0) ? 9600 : (k == 1) ? -1792 : 384;
    else c = (k == 0) ? 9984 : (k == 1) ? -2432 : (k == 2) ? 896 : -256;
    return c;
  endfunction

endpackage

// File: rtl/hb_mac.sv
module hb_mac #(
  parameter int DW    = 12,
  parameter int ORDER = 4
) (
  input  logic signed [DW-1:0] win [ORDER+1],
  output logic signed [DW-1:0] y,
  output logic                 clip_hi,
  output logic                 clip_lo
);
  localparam int FRAC  = hbdec_pkg::HB_FRAC;
  localparam int AW    = DW + FRAC + 4;
  localparam int CTR   = ORDER / 2;
  localparam int PAIRS = (ORDER + 2) / 4;
  localparam logic signed [AW-1:0] HALF = 1 <<< (FRAC - 1);
  localparam logic signed [AW-1:0] MAXA = (1 <<< (DW - 1)) - 1;
  localparam logic signed [AW-1:0] MINA = -(1 <<< (DW - 1));

  logic signed [AW-1:0] part [PAIRS+1];
  logic signed [AW-1:0] rnd;

  // Centre tap is exactly one half: a shift, no multiplier
  assign part[0] = AW'(win[CTR]) <<< (FRAC - 1);

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    localparam int OFF = 2 * k + 1;
    localparam int signed CO = hbdec_pkg::hb_coef(PAIRS, k);
    logic signed [DW:0] pre;
    // Symmetric taps share one multiplier through a pre-add
    assign pre = (DW+1)'(win[CTR-OFF]) + (DW+1)'(win[CTR+OFF]);
    assign part[k+1] = part[k] + AW'(pre) * AW'(CO);
  end

  always_comb begin
    rnd     = (part[PAIRS] + HALF) >>> FRAC;
    clip_hi = (rnd > MAXA);
    clip_lo = (rnd < MINA);
    if (clip_hi)      y = {1'b0, {(DW-1){1'b1}}};
    else if (clip_lo) y = {1'b1, {(DW-1){1'b0}}};
    else              y = rnd[DW-1:0];
  end
endmodule

// File: rtl/hb_stage.sv
module hb_stage #(
  parameter int DW    = 12,
  parameter int ORDER = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  logic                 decim_en,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);
  localparam logic signed [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

  logic signed [DW-1:0] dl_i [ORDER];
  logic signed [DW-1:0] dl_q [ORDER];
  logic signed [DW-1:0] win_i [ORDER+1];
  logic signed [DW-1:0] win_q [ORDER+1];
  logic signed [DW-1:0] y_i, y_q;
  logic hi_i, lo_i, hi_q, lo_q;
  logic phase;

  // Newest sample sits at window position 0
  always_comb begin
    win_i[0] = in_i;
    win_q[0] = in_q;
    for (int k = 1; k <= ORDER; k++) begin
      win_i[k] = dl_i[k-1];
      win_q[k] = dl_q[k-1];
    end
  end

  hb_mac #(.DW(DW), .ORDER(ORDER)) u_mac_i (
    .win(win_i), .y(y_i), .clip_hi(hi_i), .clip_lo(lo_i));
  hb_mac #(.DW(DW), .ORDER(ORDER)) u_mac_q (
    .win(win_q), .y(y_q), .clip_hi(hi_q), .clip_lo(lo_q));

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int k = 0; k < ORDER; k++) begin
        dl_i[k] <= '0;
        dl_q[k] <= '0;
      end
      phase     <= 1'b0;
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= 1'b0;
      if (in_valid) begin
        if (decim_en) begin
          for (int k = ORDER - 1; k > 0; k--) begin
            dl_i[k] <= dl_i[k-1];
            dl_q[k] <= dl_q[k-1];
          end
          dl_i[0] <= in_i;
          dl_q[0] <= in_q;
          phase   <= ~phase;
          if (phase) begin
            out_valid <= 1'b1;
            out_i     <= y_i;
            out_q     <= y_q;
          end
        end else begin
          out_valid <= 1'b1;
          out_i     <= in_i;
          out_q     <= in_q;
        end
      end
    end
  end

  // R2: a decimating stage needs two inputs per output
  assert_no_back_to_back_R2: assert property (@(posedge clk) disable iff (rst)
    (decim_en && out_valid) |=> !out_valid);

  // R6: out-of-range sums clip instead of wrapping
  assert_clip_high_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && decim_en && phase && !flush && hi_i) |=> (out_i == SMAX));
  assert_clip_low_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && decim_en && phase && !flush && lo_q) |=> (out_q == SMIN));

  // R10: a bypassed stage forwards each sample one clock later
  assert_bypass_pass_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !decim_en && !flush) |=> (out_valid && out_i == $past(in_i)));
endmodule

// File: rtl/hb_latency.sv
module hb_latency #(
  parameter int ORD1  = 4,
  parameter int ORD2  = 6,
  parameter int ORD3  = 14,
  parameter int LAT_W = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  hbdec_pkg::chain_cfg_t  cfg,
  output logic [LAT_W-1:0]       latency
);
  localparam int NST = 3;
  localparam int ORDS [NST] = '{ORD1, ORD2, ORD3};

  logic [NST-1:0]   act;
  logic [LAT_W-1:0] lat_d;
  logic             started;

  assign act = {cfg.s3, cfg.s2, cfg.s1};

  // Each active stage's delay is counted at its own input rate,
  // so it scales by two for every active stage ahead of it.
  always_comb begin
    int sum;
    int mult;
    sum  = 0;
    mult = 1;
    for (int s = 0; s < NST; s++) begin
      if (act[s]) begin
        sum  = sum + (ORDS[s] / 2) * mult;
        mult = mult * 2;
      end
    end
    lat_d = cfg.en ? LAT_W'(sum) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latency <= '0;
      started <= 1'b0;
    end else begin
      latency <= lat_d;
      started <= 1'b1;
    end
  end

  // R7: reported delay holds while the configuration holds
  assert_latency_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (started && $stable(cfg)) |=> $stable(latency));
endmodule

// File: rtl/rx_hb_decim_chain.sv
module rx_hb_decim_chain #(
  parameter int DW    = 12,
  parameter int ORD1  = 4,
  parameter int ORD2  = 6,
  parameter int ORD3  = 14,
  parameter int LAT_W = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [6:0]           ctrl_word,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q,
  output logic [LAT_W-1:0]     latency
);
  import hbdec_pkg::*;

  localparam int NST = 3;
  localparam int ORDS [NST] = '{ORD1, ORD2, ORD3};

  chain_cfg_t want, cfg_q;
  logic       reconf;
  logic [NST-1:0] dec_en;
  logic [NST:0]   vld;
  logic signed [DW-1:0] di [NST+1];
  logic signed [DW-1:0] dq [NST+1];

  assign want   = decode_ctrl(ctrl_word);
  assign reconf = (want != cfg_q);
  assign dec_en = {cfg_q.s3, cfg_q.s2, cfg_q.s1};

  // Applied configuration; any change flushes the whole chain for one clock
  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= want;
  end

  assign vld[0] = in_valid & cfg_q.en & ~reconf;
  assign di[0]  = in_i;
  assign dq[0]  = in_q;

  for (genvar g = 0; g < NST; g++) begin : g_stage
    hb_stage #(.DW(DW), .ORDER(ORDS[g])) u_stg (
      .clk      (clk),
      .rst      (rst),
      .flush    (reconf),
      .decim_en (dec_en[g]),
      .in_valid (vld[g]),
      .in_i     (di[g]),
      .in_q     (dq[g]),
      .out_valid(vld[g+1]),
      .out_i    (di[g+1]),
      .out_q    (dq[g+1])
    );
  end

  assign out_valid = vld[NST];
  assign out_i     = di[NST];
  assign out_q     = dq[NST];

  hb_latency #(.ORD1(ORD1), .ORD2(ORD2), .ORD3(ORD3), .LAT_W(LAT_W)) u_lat (
    .clk(clk), .rst(rst), .cfg(want), .latency(latency));

  // R8: a cleared channel bit silences the output from the next clock
  assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_word[6]) |=> !out_valid);
endmodule

// File: tb/sim_rx_hb_decim_chain.sv
module sim_rx_hb_decim_chain;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;

  typedef struct packed {
    logic [6:0] ctrl;
    int         lat;
    int         cnt;
    int         dc;
    logic       r1;
  } vec_t;

  localparam int NV = 11;
  // ctrl, expected latency, outputs from 256 inputs, DC level, decode-focused row
  localparam vec_t VECS [NV] = '{
    '{7'h40,  0, 256,   300, 1'b0},
    '{7'h50,  2, 128,  -700, 1'b0},
    '{7'h48,  3, 128,  1500, 1'b0},
    '{7'h44,  7, 128,    -1, 1'b0},
    '{7'h58,  8,  64,  2047, 1'b0},
    '{7'h54, 16,  64, -2048, 1'b0},
    '{7'h4C, 17,  64,   123, 1'b0},
    '{7'h5C, 36,  32,  -999, 1'b0},
    '{7'h5F, 36,  32,   555, 1'b1},
    '{7'h7C, 17,  64,    42, 1'b1},
    '{7'h1C,  0,   0,    77, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] ctrl_word = 7'h00;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_i = '0, in_q = '0;
  logic out_valid;
  logic signed [DW-1:0] out_i, out_q;
  logic [5:0] latency;

  int n_chk = 0, n_fail = 0;
  int cap_n = 0;
  int cap_i [512];
  int cap_q [512];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_hb_decim_chain u0 (
    .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .in_valid(in_valid),
    .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_i(out_i),
    .out_q(out_q), .latency(latency));

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (cap_n < 512) begin
        cap_i[cap_n] = int'(out_i);
        cap_q[cap_n] = int'(out_q);
      end
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_ctrl(input logic [6:0] v);
    @(negedge clk);
    ctrl_word = v;
    in_valid  = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic push(input int vi, input int vq);
    @(negedge clk);
    in_valid = 1'b1;
    in_i = DW'(vi);
    in_q = DW'(vq);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int c0;
    // R11: reset state with traffic and an enabled word applied
    ctrl_word = 7'h5C;
    in_valid  = 1'b1;
    in_i      = 12'sd100;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R11 out_valid", int'(out_valid), 0);
    chk(latency == 6'd0, "R11 latency", int'(latency), 0);
    rst = 1'b0;
    in_valid = 1'b0;
    ctrl_word = 7'h00;
    repeat (3) @(negedge clk);

    // Table walk: R7 latency timing, R2 counts, R3 DC gain, R1 decode rows
    for (int v = 0; v < NV; v++) begin
      int prev;
      prev = int'(latency);
      @(negedge clk);
      ctrl_word = VECS[v].ctrl;
      in_valid  = 1'b0;
      chk(int'(latency) == prev, "R7 held until clock", int'(latency), prev);
      @(negedge clk);
      chk(int'(latency) == VECS[v].lat, VECS[v].r1 ? "R1 latency" : "R7 latency",
          int'(latency), VECS[v].lat);
      repeat (2) @(negedge clk);
      cap_n = 0;
      for (int s = 0; s < 256; s++) push(VECS[v].dc, ~VECS[v].dc);
      idle(40);
      chk(cap_n == VECS[v].cnt, VECS[v].r1 ? "R1 count" : "R2 count", cap_n, VECS[v].cnt);
      if (VECS[v].cnt > 0) begin
        chk(cap_i[cap_n-1] == VECS[v].dc, "R3 dc I", cap_i[cap_n-1], VECS[v].dc);
        chk(cap_q[cap_n-1] == ~VECS[v].dc, "R3 dc Q", cap_q[cap_n-1], ~VECS[v].dc);
      end
    end

    // R4: impulse through the entry stage alone
    set_ctrl(7'h50);
    cap_n = 0;
    push(0, 0); push(1024, 0); push(0, 0); push(0, 0); push(0, 0); push(0, 0);
    idle(6);
    chk(cap_n == 3, "R4 impulse count", cap_n, 3);
    chk(cap_i[0] == 0, "R4 impulse tap0", cap_i[0], 0);
    chk(cap_i[1] == 512, "R4 impulse centre", cap_i[1], 512);
    chk(cap_i[2] == 0, "R4 impulse tap4", cap_i[2], 0);

    // R5: ties round upward
    set_ctrl(7'h10);
    set_ctrl(7'h50);
    cap_n = 0;
    push(2, -2); push(0, 0);
    idle(6);
    chk(cap_i[0] == 1, "R5 round +0.5", cap_i[0], 1);
    chk(cap_q[0] == 0, "R5 round -0.5", cap_q[0], 0);

    // R6: overshoot and undershoot of the middle stage on a full-scale step
    set_ctrl(7'h48);
    cap_n = 0;
    for (int s = 0; s < 16; s++) push(-2048, 2047);
    for (int s = 0; s < 8; s++) push(2047, -2048);
    idle(8);
    chk(cap_i[8] == -2048, "R6 clip low I", cap_i[8], -2048);
    chk(cap_i[10] == 2047, "R6 clip high I", cap_i[10], 2047);
    chk(cap_q[10] == -2048, "R6 clip low Q", cap_q[10], -2048);

    // R8: disable while streaming, then re-enable from empty history
    set_ctrl(7'h50);
    for (int s = 0; s < 20; s++) push(1000, 0);
    @(negedge clk);
    ctrl_word = 7'h10;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 silent next clock", int'(out_valid), 0);
    c0 = cap_n;
    for (int s = 0; s < 6; s++) push(1000, 0);
    idle(4);
    chk(cap_n == c0, "R8 inputs dropped", cap_n - c0, 0);
    set_ctrl(7'h50);
    cap_n = 0;
    push(1000, 0); push(1000, 0);
    idle(5);
    chk(cap_i[0] == 250, "R8 history cleared", cap_i[0], 250);

    // R9: reconfigure mid-stream, middle stage must start empty
    set_ctrl(7'h58);
    for (int s = 0; s < 40; s++) push(1000, 0);
    @(negedge clk);
    ctrl_word = 7'h48;
    @(negedge clk);
    c0 = cap_n;
    for (int s = 0; s < 8; s++) push(1000, 0);
    idle(10);
    chk(cap_i[c0] == -31, "R9 flushed on change", cap_i[c0], -31);
    chk(int'(latency) == 3, "R9 latency after change", int'(latency), 3);

    // R10: full bypass, three clocks through
    set_ctrl(7'h40);
    @(negedge clk);
    in_valid = 1'b1;
    in_i = 12'sd777;
    in_q = -12'sd5;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R10 not after 1", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 not after 2", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R10 valid after 3", int'(out_valid), 1);
    chk(int'(out_i) == 777, "R10 I unchanged", int'(out_i), 777);
    chk(int'(out_q) == -5, "R10 Q unchanged", int'(out_q), -5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule